// File: doc/BRIEF.md
# Four-Phase Nanoinstruction Executor

This block sequences a two-level control store. Each wide nanoinstruction holds one persistent control field (K) and four operation fields (T1 to T4). The executor keeps K on its output for the whole nanoinstruction and issues one operation field per clock cycle, in order. Each output cycle therefore carries a 144-bit control word made of K and the current operation field. The datapath that consumes these bits is outside the block.

The nanostore sits outside the executor behind a combinational read port. The block drives the address and receives the 360-bit word in the same cycle. It does not register the word. Three sequencing mechanisms are built in. A repeat bit in an operation field restarts the same nanoinstruction until a selected condition becomes true. A skip bit blanks the following operation field when the selected condition is true. A branch address held in K chooses the next nanoinstruction. The condition is one bit of a 16-bit condition vector, picked by a select subfield in K.

Top module: `nanoSequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, phase is 0, nanoAddr is 0 and ctrlWord shows K and T1 of the word at address 0.
- R2: Word layout is K in bits 359:288, T1 in 287:216, T2 in 215:144, T3 in 143:72 and T4 in 71:0. ctrlWord is {K, current T}. Phase steps 0, 1, 2, 3 (T1..T4), one per cycle.
- R3: nanoAddr and the K half of ctrlWord stay unchanged across the phases of one nanoinstruction.
- R4: After phase 3 with no active repeat, nanoAddr becomes K bits 9:0 and phase returns to 0.
- R5: An operation field's skip bit (bit 1) in phases 0 to 2 makes the next phase a blank phase when the selected condition cond[K bits 13:10] is 1. A blank phase outputs K with an all-zero T and still takes one cycle. A skip bit in T4 has no effect.
- R6: An active repeat bit (T bit 0) with the selected condition at 0 returns phase to 0 at the same nanoAddr.
- R7: An active repeat bit with the selected condition at 1 ends the nanoinstruction. nanoAddr becomes K bits 9:0 and phase becomes 0.
- R8: Repeat and skip bits inside a blanked field have no effect. The phase advances normally.
- R9: A skip bit with the selected condition at 0 does not blank the next phase. Only the selected condition bit matters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nanoWord | input | 360 | Nanostore read data for nanoAddr |
| cond | input | 16 | Condition vector |
| nanoAddr | output | 10 | Nanostore read address |
| ctrlWord | output | 144 | K followed by current (or blanked) operation field |
| phase | output | 2 | Current phase, 0 = T1 .. 3 = T4 |

## Verification
A nanoinstruction with no control bits set shows the plain four-phase order, the persistent K half and the branch at the end. A nanoinstruction with skip bits in every field separates three cases: a taken skip, a skip whose condition is low, and a skip bit in T4. In the same test, a blanked field carrying repeat and skip bits shows whether the block wrongly obeys a field it has hidden. A repeat field is driven first with every condition bit high except the selected one, then with only the selected one high. The first run catches a wrong condition select. The second tells restart apart from completion.

// File: rtl/nanoPkg.sv
package nanoPkg;
  localparam int FIELD_W = 72;
  localparam int NUM_T   = 4;
  localparam int ADDR_W  = 10;
  localparam int COND_W  = 16;
  localparam int SEL_W   = $clog2(COND_W);
  localparam int PH_W    = $clog2(NUM_T);
  localparam int WORD_W  = FIELD_W * (NUM_T + 1);
  localparam int CTRL_W  = 2 * FIELD_W;
  localparam int REP_BIT  = 0;
  localparam int SKIP_BIT = 1;
  localparam int SEL_LSB  = ADDR_W;

  typedef struct packed {
    logic            takeBranch;
    logic            blankT;
    logic [PH_W-1:0] phase;
  } seqStrobe_t;
endpackage

// File: rtl/nanoCtrl.sv
module nanoCtrl
  import nanoPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tRepeat,
  input  logic       tSkip,
  input  logic       condHit,
  output seqStrobe_t strb
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_T - 1);

  logic [PH_W-1:0] phaseQ, phaseD;
  logic            skipQ, skipD;
  logic            branch;
  logic            active;

  always_comb begin
    active = !skipQ;
    phaseD = PH_W'(phaseQ + 1'b1);
    skipD  = 1'b0;
    branch = 1'b0;
    if (active && tRepeat) begin
      phaseD = '0;
      branch = condHit;
    end else if (phaseQ == LAST_PH) begin
      phaseD = '0;
      branch = 1'b1;
    end else begin
      skipD = active && tSkip && condHit;
    end
    strb.takeBranch = branch;
    strb.blankT     = skipQ;
    strb.phase      = phaseQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= '0;
      skipQ  <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      skipQ  <= skipD;
    end
  end
endmodule

// File: rtl/nanoPath.sv
module nanoPath
  import nanoPkg::*;
#(
  parameter logic [nanoPkg::ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] nanoWord,
  input  logic [COND_W-1:0] cond,
  input  seqStrobe_t        strb,
  output logic [ADDR_W-1:0] nanoAddr,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              tRepeat,
  output logic              tSkip,
  output logic              condHit
);
  logic [FIELD_W-1:0] kField;
  logic [FIELD_W-1:0] tArr [NUM_T];
  logic [FIELD_W-1:0] tOut;
  logic [SEL_W-1:0]   condSel;
  logic [ADDR_W-1:0]  addrQ;

  assign kField = nanoWord[WORD_W-1 -: FIELD_W];

  for (genvar g = 0; g < NUM_T; g++) begin : gSlice
    assign tArr[g] = nanoWord[WORD_W-1-FIELD_W*(g+1) -: FIELD_W];
  end

  assign tOut     = strb.blankT ? '0 : tArr[strb.phase];
  assign ctrlWord = {kField, tOut};
  assign tRepeat  = tOut[REP_BIT];
  assign tSkip    = tOut[SKIP_BIT];
  assign condSel  = kField[SEL_LSB +: SEL_W];
  assign condHit  = cond[condSel];
  assign nanoAddr = addrQ;

  always_ff @(posedge clk) begin
    if (rst)                  addrQ <= RESET_ADDR;
    else if (strb.takeBranch) addrQ <= kField[ADDR_W-1:0];
  end
endmodule

// File: rtl/nanoSequencer.sv
module nanoSequencer
  import nanoPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] nanoWord,
  input  logic [COND_W-1:0] cond,
  output logic [ADDR_W-1:0] nanoAddr,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic [PH_W-1:0]   phase
);
  seqStrobe_t strb;
  logic tRepeat, tSkip, condHit;

  nanoCtrl u_ctrl (
    .clk(clk), .rst(rst), .tRepeat(tRepeat), .tSkip(tSkip),
    .condHit(condHit), .strb(strb)
  );

  nanoPath #(.RESET_ADDR('0)) u_path (
    .clk(clk), .rst(rst), .nanoWord(nanoWord), .cond(cond), .strb(strb),
    .nanoAddr(nanoAddr), .ctrlWord(ctrlWord), .tRepeat(tRepeat),
    .tSkip(tSkip), .condHit(condHit)
  );

  assign phase = strb.phase;
endmodule

// File: rtl/nanoSequencer_chk.sv
module nanoSequencer_chk
  import nanoPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [COND_W-1:0] cond,
  input logic [ADDR_W-1:0] nanoAddr,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic [PH_W-1:0]   phase
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_T - 1);
  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] br;
  logic              hit, rep, skp;
  assign sel = ctrlWord[FIELD_W+SEL_LSB +: SEL_W];
  assign br  = ctrlWord[FIELD_W +: ADDR_W];
  assign hit = cond[sel];
  assign rep = ctrlWord[REP_BIT];
  assign skp = ctrlWord[SKIP_BIT];

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase != LAST_PH && !rep) |=> phase == PH_W'($past(phase) + 1'b1)); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (phase != LAST_PH && !rep) |=> $stable(nanoAddr)); // R3
  AST_K_HELD: assert property (@(posedge clk) disable iff (rst)
    (phase != LAST_PH && !rep) |=> $stable(ctrlWord[CTRL_W-1:FIELD_W])); // R3
  AST_END_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (phase == LAST_PH && !rep) |=> (phase == '0 && nanoAddr == $past(br))); // R4
  AST_SKIP_BLANK: assert property (@(posedge clk) disable iff (rst)
    (skp && !rep && hit && phase != LAST_PH) |=> ctrlWord[FIELD_W-1:0] == '0); // R5
  AST_REPEAT_AGAIN: assert property (@(posedge clk) disable iff (rst)
    (rep && !hit) |=> (phase == '0 && $stable(nanoAddr))); // R6
  AST_REPEAT_DONE: assert property (@(posedge clk) disable iff (rst)
    (rep && hit) |=> (phase == '0 && nanoAddr == $past(br))); // R7
endmodule

bind nanoSequencer nanoSequencer_chk u_chk (.*);

// File: tb/nanoSequencer_tb.sv
`timescale 1ns/1ps
module nanoSequencer_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [15:0]  cond = '0;
  logic [359:0] nanoWord;
  logic [9:0]   nanoAddr;
  logic [143:0] ctrlWord;
  logic [1:0]   phase;
  logic [359:0] mem [0:1023];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign nanoWord = mem[nanoAddr];

  nanoSequencer u_dut (
    .clk(clk), .rst(rst), .nanoWord(nanoWord), .cond(cond),
    .nanoAddr(nanoAddr), .ctrlWord(ctrlWord), .phase(phase)
  );

  function automatic logic [71:0] mkK(input logic [9:0] br, input logic [3:0] sel);
    return {58'h15A5A3C, sel, br};
  endfunction
  function automatic logic [71:0] mkT(input logic [7:0] tag, input logic skp, input logic rep);
    return {62'h0F0F, tag, skp, rep};
  endfunction

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic doReset;
    rst = 1'b1; cond = '0;
    tick; tick;
    rst = 1'b0;
  endtask

  task automatic chk(input string req, input logic [9:0] eA, input logic [1:0] eP,
                     input logic [71:0] eK, input logic [71:0] eT);
    logic [155:0] act, exp;
    act = {nanoAddr, phase, ctrlWord};
    exp = {eA, eP, eK, eT};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tReset;
    mem[0] = {mkK(10'd5, 4'd2), mkT(8'h01,0,0), mkT(8'h02,0,0), mkT(8'h03,0,0), mkT(8'h04,0,0)};
    mem[5] = {mkK(10'd0, 4'd1), mkT(8'h51,0,0), mkT(8'h52,0,0), mkT(8'h53,0,0), mkT(8'h54,0,0)};
    rst = 1'b1; tick; tick;
    chk("R1 in reset", 10'd0, 2'd0, mkK(10'd5,4'd2), mkT(8'h01,0,0));
    rst = 1'b0;
    chk("R1 after reset", 10'd0, 2'd0, mkK(10'd5,4'd2), mkT(8'h01,0,0));
  endtask

  task automatic tSequence;
    doReset;
    chk("R2 phase0", 10'd0, 2'd0, mkK(10'd5,4'd2), mkT(8'h01,0,0));
    tick; chk("R2 R3 phase1", 10'd0, 2'd1, mkK(10'd5,4'd2), mkT(8'h02,0,0));
    tick; chk("R2 R3 phase2", 10'd0, 2'd2, mkK(10'd5,4'd2), mkT(8'h03,0,0));
    tick; chk("R2 R3 phase3", 10'd0, 2'd3, mkK(10'd5,4'd2), mkT(8'h04,0,0));
    tick; chk("R4 branch", 10'd5, 2'd0, mkK(10'd0,4'd1), mkT(8'h51,0,0));
    tick; chk("R2 next word", 10'd5, 2'd1, mkK(10'd0,4'd1), mkT(8'h52,0,0));
  endtask

  task automatic tSkip;
    mem[0]  = {mkK(10'd12, 4'd3), mkT(8'h11,1,0), mkT(8'h22,1,1), mkT(8'h33,1,0), mkT(8'h44,1,0)};
    mem[12] = {mkK(10'd0, 4'd0), mkT(8'hC1,0,0), mkT(8'hC2,0,0), mkT(8'hC3,0,0), mkT(8'hC4,0,0)};
    doReset;
    cond = 16'h0008;
    chk("R5 skip source", 10'd0, 2'd0, mkK(10'd12,4'd3), mkT(8'h11,1,0));
    tick; chk("R5 blank phase", 10'd0, 2'd1, mkK(10'd12,4'd3), 72'h0);
    cond = 16'h0000;
    tick; chk("R8 blanked bits ignored", 10'd0, 2'd2, mkK(10'd12,4'd3), mkT(8'h33,1,0));
    cond = 16'hFFF7;
    tick; chk("R9 skip cond low", 10'd0, 2'd3, mkK(10'd12,4'd3), mkT(8'h44,1,0));
    cond = 16'h0008;
    tick; chk("R5 T4 skip no effect", 10'd12, 2'd0, mkK(10'd0,4'd0), mkT(8'hC1,0,0));
  endtask

  task automatic tRepeat;
    mem[0] = {mkK(10'd9, 4'd7), mkT(8'h61,0,0), mkT(8'h62,0,1), mkT(8'h63,0,0), mkT(8'h64,0,0)};
    mem[9] = {mkK(10'd0, 4'd0), mkT(8'h91,0,0), mkT(8'h92,0,0), mkT(8'h93,0,0), mkT(8'h94,0,0)};
    doReset;
    cond = 16'hFF7F;
    tick; chk("R6 repeat field", 10'd0, 2'd1, mkK(10'd9,4'd7), mkT(8'h62,0,1));
    tick; chk("R6 restart", 10'd0, 2'd0, mkK(10'd9,4'd7), mkT(8'h61,0,0));
    tick; chk("R6 second pass", 10'd0, 2'd1, mkK(10'd9,4'd7), mkT(8'h62,0,1));
    cond = 16'h0080;
    tick; chk("R7 repeat done", 10'd9, 2'd0, mkK(10'd0,4'd0), mkT(8'h91,0,0));
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    tReset;
    tSequence;
    tSkip;
    tRepeat;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule